// File: doc/BRIEF.md
# Decimal Conditional-Sum Prefix Adder

This block is a purely combinational decimal adder. It takes two digit vectors of equal length and returns their sum as plain BCD plus a decimal carry-out. The first operand holds each digit in excess-6 form, so a digit of value v is the 4-bit code v+6. The second operand holds each digit in plain BCD. This redundant pair is the typical output of a decimal carry-save reduction stage, and the block turns it into one non-redundant result.

Each digit position works out two candidate sums ahead of time, one for an incoming carry of zero and one for an incoming carry of one, and applies its decimal correction locally. The carry-outs of these two candidates serve as the digit's generate and propagate terms. A logarithmic-depth parallel prefix network combines those terms into the carry entering every digit. A last row of 2:1 selectors then picks each digit's candidate. No carry ripples through the digit logic, so the delay grows with the logarithm of the width.

Top module: `decimal_cs_adder`

## Requirements
- R1: Operand A digit i occupies bits [4i+3:4i] of `opA` and holds value v in 0..9 as code v+6; operand B digit i occupies bits [4i+3:4i] of `opB` as plain BCD 0..9; digit 0 is least significant.
- R2: Every 4-bit digit of `sumOut` is a valid BCD code in 0..9 whenever all input digits are valid.
- R3: The decimal value of `carryOut` followed by `sumOut` equals the decimal value of A (after removing the excess of 6 per digit) plus the decimal value of B.
- R4: `carryOut` is 1 exactly when the true sum reaches 10 to the power of the digit count.
- R5: There is no carry input, so the carry into digit 0 is zero: A and B both zero give a sum of zero and no carry-out.
- R6: A carry born in digit 0 propagates through any run of digit pairs that sum to 9, up to and including `carryOut`, for example all nines plus one.
- R7: Every digit pair may sum to 18 at once; all nines plus all nines gives a carry-out of 1 and digits 8 followed by nines.
- R8: A digit pair that sums to exactly 9 turns an incoming carry into a sum digit of 0 and passes the carry on; a pair summing to less than 9 absorbs the carry.
- R9: Each sum digit equals (A digit value + B digit value + incoming carry) modulo 10, and the carry into the next digit is 1 exactly when that total reaches 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 4*NUM_DIGITS | Operand A, excess-6 digits |
| opB | input | 4*NUM_DIGITS | Operand B, BCD digits |
| sumOut | output | 4*NUM_DIGITS | BCD sum digits |
| carryOut | output | 1 | Decimal carry-out of the top digit |

## Verification
The adder has no registers, so every result is due as soon as the inputs settle, in the same cycle they are applied. The bench drives new operands just after a rising clock edge and samples `sumOut` and `carryOut` on the following falling edge. Half a period has passed by then and no other input has changed, so each check sees exactly the response to the operands just applied.

// File: rtl/decadd_pkg.sv
package decadd_pkg;
  localparam int DIGIT_BITS = 4;
  localparam int EXCESS = 6;

  typedef logic [DIGIT_BITS-1:0] digit_t;

  // Carry strobes a digit hands to the prefix network
  typedef struct packed {
    logic gen;   // carry-out when carry-in is 0
    logic prop;  // carry-out when carry-in is 1
  } gpPair_t;
endpackage

// File: rtl/dec_digit_cond.sv
module dec_digit_cond
  import decadd_pkg::*;
(
  input  digit_t  aDigit,
  input  digit_t  bDigit,
  output digit_t  sumNoCarry,
  output digit_t  sumWithCarry,
  output gpPair_t gpOut
);
  logic [DIGIT_BITS:0] rawLow;
  logic [DIGIT_BITS:0] rawHigh;

  // A carries an excess of 6, so the 4-bit binary sum wraps exactly
  // when the decimal digit sum reaches 10; otherwise remove the excess.
  always_comb begin
    rawLow  = {1'b0, aDigit} + {1'b0, bDigit};
    rawHigh = rawLow + 5'd1;
    sumNoCarry   = rawLow[DIGIT_BITS]  ? rawLow[DIGIT_BITS-1:0]
                                       : rawLow[DIGIT_BITS-1:0] - digit_t'(EXCESS);
    sumWithCarry = rawHigh[DIGIT_BITS] ? rawHigh[DIGIT_BITS-1:0]
                                       : rawHigh[DIGIT_BITS-1:0] - digit_t'(EXCESS);
    gpOut.gen  = rawLow[DIGIT_BITS];
    gpOut.prop = rawHigh[DIGIT_BITS];
  end
endmodule

// File: rtl/dec_carry_prefix.sv
module dec_carry_prefix
  import decadd_pkg::*;
#(
  parameter int NUM_DIGITS = 8
) (
  input  gpPair_t [NUM_DIGITS-1:0] gpIn,
  output logic    [NUM_DIGITS-1:0] carryIn,
  output logic                     carryOut
);
  localparam int LEVELS = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 0;

  logic [NUM_DIGITS-1:0] gCur, pCur, gNxt, pNxt;

  // Span-doubling prefix tree; prop already includes gen, so the
  // combine is G = Gh | (Ph & Gl), P = Ph & Pl.
  always_comb begin
    for (int i = 0; i < NUM_DIGITS; i++) begin
      gCur[i] = gpIn[i].gen;
      pCur[i] = gpIn[i].prop;
    end
    gNxt = gCur;
    pNxt = pCur;
    for (int lv = 0; lv < LEVELS; lv++) begin
      for (int i = 0; i < NUM_DIGITS; i++) begin
        if (i >= (1 << lv)) begin
          gNxt[i] = gCur[i] | (pCur[i] & gCur[i - (1 << lv)]);
          pNxt[i] = pCur[i] & pCur[i - (1 << lv)];
        end else begin
          gNxt[i] = gCur[i];
          pNxt[i] = pCur[i];
        end
      end
      gCur = gNxt;
      pCur = pNxt;
    end
    carryIn[0] = 1'b0;
    for (int i = 1; i < NUM_DIGITS; i++) carryIn[i] = gCur[i-1];
    carryOut = gCur[NUM_DIGITS-1];
  end
endmodule

// File: rtl/dec_sum_select.sv
module dec_sum_select
  import decadd_pkg::*;
#(
  parameter int NUM_DIGITS = 8
) (
  input  logic [DIGIT_BITS*NUM_DIGITS-1:0] condLow,
  input  logic [DIGIT_BITS*NUM_DIGITS-1:0] condHigh,
  input  logic [NUM_DIGITS-1:0]            carryIn,
  output logic [DIGIT_BITS*NUM_DIGITS-1:0] sumOut
);
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_mux
    assign sumOut[DIGIT_BITS*i +: DIGIT_BITS] = carryIn[i]
                                              ? condHigh[DIGIT_BITS*i +: DIGIT_BITS]
                                              : condLow[DIGIT_BITS*i +: DIGIT_BITS];
  end
endmodule

// File: rtl/decimal_cs_adder.sv
module decimal_cs_adder
  import decadd_pkg::*;
#(
  parameter int NUM_DIGITS = 8
) (
  input  logic [DIGIT_BITS*NUM_DIGITS-1:0] opA,
  input  logic [DIGIT_BITS*NUM_DIGITS-1:0] opB,
  output logic [DIGIT_BITS*NUM_DIGITS-1:0] sumOut,
  output logic                             carryOut
);
  localparam int VEC_BITS = DIGIT_BITS * NUM_DIGITS;

  logic [VEC_BITS-1:0]             condLow, condHigh;
  gpPair_t [NUM_DIGITS-1:0]        gpVec;
  logic [NUM_DIGITS-1:0]           digitCarry;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    dec_digit_cond u_cond (
      .aDigit       (opA[DIGIT_BITS*i +: DIGIT_BITS]),
      .bDigit       (opB[DIGIT_BITS*i +: DIGIT_BITS]),
      .sumNoCarry   (condLow[DIGIT_BITS*i +: DIGIT_BITS]),
      .sumWithCarry (condHigh[DIGIT_BITS*i +: DIGIT_BITS]),
      .gpOut        (gpVec[i])
    );
  end

  dec_carry_prefix #(.NUM_DIGITS(NUM_DIGITS)) u_prefix (
    .gpIn     (gpVec),
    .carryIn  (digitCarry),
    .carryOut (carryOut)
  );

  dec_sum_select #(.NUM_DIGITS(NUM_DIGITS)) u_select (
    .condLow  (condLow),
    .condHigh (condHigh),
    .carryIn  (digitCarry),
    .sumOut   (sumOut)
  );
endmodule

// File: rtl/decimal_cs_adder_chk.sv
module decimal_cs_adder_chk
  import decadd_pkg::*;
#(
  parameter int NUM_DIGITS = 8
) (
  input logic [DIGIT_BITS*NUM_DIGITS-1:0] opA,
  input logic [DIGIT_BITS*NUM_DIGITS-1:0] opB,
  input logic [DIGIT_BITS*NUM_DIGITS-1:0] sumOut,
  input logic                             carryOut,
  input logic [NUM_DIGITS-1:0]            digitCarry,
  input gpPair_t [NUM_DIGITS-1:0]         gpVec
);
  logic allValid;

  always_comb begin
    allValid = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (opA[DIGIT_BITS*i +: DIGIT_BITS] < digit_t'(EXCESS)) allValid = 1'b0;
      if (opB[DIGIT_BITS*i +: DIGIT_BITS] > 4'd9) allValid = 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_chk
    logic nextCarry;
    int   digitTotal;
    if (i < NUM_DIGITS - 1) begin : g_mid
      assign nextCarry = digitCarry[i+1];
    end else begin : g_top
      assign nextCarry = carryOut;
    end

    always_comb begin
      digitTotal = int'(opA[DIGIT_BITS*i +: DIGIT_BITS]) - EXCESS
                 + int'(opB[DIGIT_BITS*i +: DIGIT_BITS]) + int'(digitCarry[i]);
      if (allValid) begin
        assert_digit_bcd_R2 : assert (sumOut[DIGIT_BITS*i +: DIGIT_BITS] <= 4'd9)
          else $error("digit %0d not BCD", i);
        assert_digit_value_R9 : assert (int'(sumOut[DIGIT_BITS*i +: DIGIT_BITS]) == digitTotal % 10)
          else $error("digit %0d value mismatch", i);
        assert_carry_link_R4 : assert (nextCarry == (digitTotal >= 10))
          else $error("carry out of digit %0d wrong", i);
        assert_gen_prop_R8 : assert (!gpVec[i].gen || gpVec[i].prop)
          else $error("generate without propagate at digit %0d", i);
      end
    end
  end
endmodule

bind decimal_cs_adder decimal_cs_adder_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .opA        (opA),
  .opB        (opB),
  .sumOut     (sumOut),
  .carryOut   (carryOut),
  .digitCarry (digitCarry),
  .gpVec      (gpVec)
);

// File: tb/tb_decimal_cs_adder.sv
`timescale 1ns/1ps
module tb_decimal_cs_adder;
  localparam int ND = 8;
  localparam int VB = 4 * ND;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [VB-1:0] opA, opB, sumOut;
  logic          carryOut;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  decimal_cs_adder #(.NUM_DIGITS(ND)) dut (
    .opA(opA), .opB(opB), .sumOut(sumOut), .carryOut(carryOut)
  );

  function automatic longint pow10(input int n);
    longint r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  // Digit vector (value digits) to integer
  function automatic longint vecToInt(input logic [VB-1:0] v);
    longint r = 0;
    for (int i = ND - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  // Integer to BCD vector; excessA adds 6 to each digit (R1 encoding)
  function automatic logic [VB-1:0] intToVec(input longint val, input bit excessA);
    logic [VB-1:0] r;
    longint t = val;
    for (int i = 0; i < ND; i++) begin
      r[4*i +: 4] = 4'(t % 10) + (excessA ? 4'd6 : 4'd0);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic applyAndCheck(input longint xVal, input longint yVal, input string req);
    longint total, expSum, actSum;
    bit bcdOk;
    @(posedge clk);
    #1;
    opA = intToVec(xVal, 1'b1);
    opB = intToVec(yVal, 1'b0);
    total  = xVal + yVal;
    expSum = total % pow10(ND);
    @(negedge clk);
    bcdOk = 1'b1;
    for (int i = 0; i < ND; i++) if (sumOut[4*i +: 4] > 4'd9) bcdOk = 1'b0;
    check(bcdOk, {req, " R2 digits BCD"}, longint'(bcdOk), 1);
    actSum = vecToInt(sumOut);
    check(actSum == expSum, {req, " R3 sum"}, actSum, expSum);
    check(carryOut == (total >= pow10(ND)), {req, " R4 carryOut"},
          longint'(carryOut), longint'(total >= pow10(ND)));
  endtask

  initial begin
    longint maxVal, x, y;
    opA = '0;
    opB = '0;
    maxVal = pow10(ND) - 1;
    void'($urandom(32'd20240611));

    // R5: zero operands, no carry input
    applyAndCheck(0, 0, "R5 zero");
    // R1: single digit encodings
    applyAndCheck(3, 4, "R1 small");
    applyAndCheck(5, 5, "R1 digit carry");
    // R6: long propagate chain
    applyAndCheck(maxVal, 1, "R6 nines plus one");
    applyAndCheck(1, maxVal, "R6 one plus nines");
    applyAndCheck(45454545, 54545455, "R6 mixed nine pairs");
    // R7: every pair sums to 18
    applyAndCheck(maxVal, maxVal, "R7 all eighteen");
    applyAndCheck(maxVal, 0, "R7 nines plus zero");
    // R8: exact-nine pairs pass carry, smaller pairs absorb it
    applyAndCheck(1234, 8766, "R8 nine pass");
    applyAndCheck(1204, 8706, "R8 absorb");
    // R9: random per-digit behaviour
    for (int n = 0; n < 400; n++) begin
      x = longint'($urandom) % (maxVal + 1);
      y = longint'($urandom) % (maxVal + 1);
      applyAndCheck(x, y, "R9 random");
    end
    // R9: random nine-heavy values
    for (int n = 0; n < 100; n++) begin
      x = 0;
      y = 0;
      for (int i = 0; i < ND; i++) begin
        x = x * 10 + (($urandom % 4 == 0) ? longint'($urandom % 10) : 9);
        y = y * 10 + (($urandom % 2 == 0) ? longint'($urandom % 10) : 0);
      end
      applyAndCheck(x, y, "R9 nine heavy");
    end
    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule